// File: doc/BRIEF.md
# Lock and Fuse Protection Controller

This block holds the non-volatile configuration of a small flash device while it is in parallel programming. There are two lock bits and a five-bit fuse word. The fuse word has a 4-bit clock-select field in bits 3:0 and a load-capacitor fuse in bit 4. The block also answers reads of three fixed signature bytes and of one oscillator calibration byte. A programmer sends one command per cycle on a valid/opcode/address/data interface. The controller decides whether each flash write or flash verify may reach the array. When a request is refused, it raises a one-cycle error.

A bit is "programmed" at 0 and "unprogrammed" at 1. Every programming command is an AND of the old value with the written value, so it can only clear bits. The lock bits set three protection levels. When LB1 is cleared, flash and fuse writes are blocked. When LB2 is also cleared, flash verify is blocked as well. The only way to raise the lock bits again is chip erase. Chip erase occupies the block for a fixed number of cycles and leaves the fuses alone.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: After reset both lock bits are 1, the fuse word is 5'b1_0010 (load-capacitor fuse 1, clock-select 4'b0010), and busy, errPulse, rspValid, flashWrEn and flashRdEn are all 0.
- R2: A lock or fuse programming command stores old AND new. A 1 written over a 0 leaves it at 0. Fuse data comes from cmdData[4:0]; lock data comes from cmdData[1:0] (bit 0 = LB1, bit 1 = LB2).
- R3: While LB1 is 0, flash program (opcode 6) and fuse program (opcode 1) are refused. errPulse is high for exactly the one cycle after the command. There is no flashWrEn and the fuses stay unchanged.
- R4: While LB1 is 1, flash program asserts flashWrEn for one cycle, one cycle after the command. In that cycle flashAddr equals cmdAddr and flashWrData equals cmdData.
- R5: Flash verify (opcode 7) with both lock bits 0 returns rspValid with rspData 0x00 and errPulse one cycle later, and flashRdEn stays low. In any other lock state, flashRdEn and busy are high in the next cycle with flashAddr equal to cmdAddr. One cycle after that, rspValid returns the flashRdData seen in that cycle.
- R6: Chip erase (opcode 2) holds busy high for exactly ERASE_CYCLES cycles, starting the cycle after the command. When busy falls, both lock bits read 1 and the fuses are unchanged.
- R7: Commands presented while busy is high are ignored. They produce no error, no response and no flash strobe, and they change no lock or fuse bit.
- R8: Signature read (opcode 3) uses cmdAddr[1:0] as index and cmdData[0] as high-byte select. Low bytes are 0x1E, 0x91, 0x07 and 0x00 for indices 0 to 3. The high byte at index 0 is the CAL_BYTE parameter, and every other high byte is 0x00.
- R9: Lock programming (opcode 0) is accepted in every lock state, including full lock.
- R10: Fuse read (opcode 4) returns {3'b000, fuse word} and lock read (opcode 5) returns {6'b0, LB2, LB1}. Every read response appears with rspValid one cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, restores fresh-device state |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command opcode |
| cmdAddr | input | ADDR_W | Flash address, or signature index in bits 1:0 |
| cmdData | input | 8 | Write data, or high-byte select in bit 0 for signature reads |
| flashRdData | input | 8 | Data returned by the flash array for a verify |
| busy | output | 1 | Erase or verify in progress; commands ignored |
| errPulse | output | 1 | One-cycle flag for a refused request |
| rspValid | output | 1 | Read response valid |
| rspData | output | 8 | Read response data |
| flashWrEn | output | 1 | Granted flash byte write strobe |
| flashRdEn | output | 1 | Granted flash verify read strobe |
| flashAddr | output | ADDR_W | Flash address for the current write or verify |
| flashWrData | output | 8 | Flash write data |

## Verification
The bound checker watches the protection invariants on every cycle. No write strobe appears while LB1 is 0, and no verify read appears under full lock. The fuses never move while they are locked, and a lock bit rises only at the cycle in which an erase ends. At most one of the error, write and verify-read strobes is high in any cycle. Only the bench scenarios can show the rest: the exact response values and their latency, the erase length in cycles, and the fact that commands issued during busy leave no trace. The bench compares these against a small reference model of the lock and fuse bits.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  localparam int LOCK_W  = 2;
  localparam int CKSEL_W = 4;
  localparam int FUSE_W  = CKSEL_W + 1;
  localparam int BYTE_W  = 8;

  localparam logic [LOCK_W-1:0] LOCK_FRESH   = '1;
  localparam logic [FUSE_W-1:0] FUSE_DEFAULT = {1'b1, 4'b0010};

  typedef enum logic [2:0] {
    OP_LOCK_PROG  = 3'd0,
    OP_FUSE_PROG  = 3'd1,
    OP_ERASE      = 3'd2,
    OP_SIG_RD     = 3'd3,
    OP_FUSE_RD    = 3'd4,
    OP_LOCK_RD    = 3'd5,
    OP_FLASH_PROG = 3'd6,
    OP_FLASH_VFY  = 3'd7
  } cmdOp_e;

  typedef enum logic [2:0] {
    RSP_SIG   = 3'd0,
    RSP_FUSE  = 3'd1,
    RSP_LOCK  = 3'd2,
    RSP_ZERO  = 3'd3,
    RSP_FLASH = 3'd4
  } rspSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    lockWr;
    logic    lockClr;
    logic    fuseWr;
    logic    addrLoad;
    logic    rspLoad;
    rspSel_e rspSel;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_lock_sig.sv
module cfg_lock_sig
  import cfg_lock_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CAL_BYTE = 8'h9C
) (
  input  logic [1:0]        sigIdx,
  input  logic              hiSel,
  output logic [BYTE_W-1:0] sigByte
);

  logic [BYTE_W-1:0] loByte;
  logic [BYTE_W-1:0] hiByte;

  always_comb begin
    unique case (sigIdx)
      2'd0:    loByte = 8'h1E;
      2'd1:    loByte = 8'h91;
      2'd2:    loByte = 8'h07;
      default: loByte = 8'h00;
    endcase
  end

  assign hiByte  = (sigIdx == 2'd0) ? CAL_BYTE : 8'h00;
  assign sigByte = hiSel ? hiByte : loByte;

endmodule

// File: rtl/cfg_lock_dp.sv
module cfg_lock_dp
  import cfg_lock_pkg::*;
#(
  parameter int                ADDR_W   = 11,
  parameter logic [BYTE_W-1:0] CAL_BYTE = 8'h9C
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic [BYTE_W-1:0] flashRdData,
  output logic [LOCK_W-1:0] lockBits,
  output logic [FUSE_W-1:0] fuseBits,
  output logic              wrLocked,
  output logic              vfyLocked,
  output logic [BYTE_W-1:0] rspData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [BYTE_W-1:0] flashWrData
);

  localparam int PAD_FUSE = BYTE_W - FUSE_W;
  localparam int PAD_LOCK = BYTE_W - LOCK_W;

  logic [BYTE_W-1:0] sigByte;
  logic [BYTE_W-1:0] rspNext;

  cfg_lock_sig #(.CAL_BYTE(CAL_BYTE)) u_sig (
    .sigIdx (cmdAddr[1:0]),
    .hiSel  (cmdData[0]),
    .sigByte(sigByte)
  );

  // LB1 (bit 0) blocks writes; both bits cleared also block verify
  assign wrLocked  = ~lockBits[0];
  assign vfyLocked = (lockBits == '0);

  always_comb begin
    unique case (strobe.rspSel)
      RSP_SIG:   rspNext = sigByte;
      RSP_FUSE:  rspNext = {{PAD_FUSE{1'b0}}, fuseBits};
      RSP_LOCK:  rspNext = {{PAD_LOCK{1'b0}}, lockBits};
      RSP_FLASH: rspNext = flashRdData;
      default:   rspNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits    <= LOCK_FRESH;
      fuseBits    <= FUSE_DEFAULT;
      rspData     <= '0;
      flashAddr   <= '0;
      flashWrData <= '0;
    end else begin
      if (strobe.lockClr)     lockBits <= LOCK_FRESH;
      else if (strobe.lockWr) lockBits <= lockBits & cmdData[LOCK_W-1:0];
      if (strobe.fuseWr)      fuseBits <= fuseBits & cmdData[FUSE_W-1:0];
      if (strobe.addrLoad) begin
        flashAddr   <= cmdAddr;
        flashWrData <= cmdData;
      end
      if (strobe.rspLoad)     rspData <= rspNext;
    end
  end

endmodule

// File: rtl/cfg_lock_ctl.sv
module cfg_lock_ctl
  import cfg_lock_pkg::*;
#(
  parameter int ERASE_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic [2:0] cmdOp,
  input  logic      wrLocked,
  input  logic      vfyLocked,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      errPulse,
  output logic      rspValid,
  output logic      flashWrEn,
  output logic      flashRdEn
);

  localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_VERIFY} ctlState_e;

  ctlState_e        state, stateNext;
  logic [CNT_W-1:0] eraseCnt, eraseCntNext;
  logic             errNext, rspNext, wrNext;
  logic             accept;
  cmdOp_e           op;

  assign accept = cmdValid && (state == ST_IDLE);
  assign op     = cmdOp_e'(cmdOp);

  always_comb begin
    strobe       = '0;
    strobe.rspSel = RSP_ZERO;
    stateNext    = state;
    eraseCntNext = eraseCnt;
    errNext      = 1'b0;
    rspNext      = 1'b0;
    wrNext       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_LOCK_PROG: strobe.lockWr = 1'b1;
            OP_FUSE_PROG: begin
              if (wrLocked) errNext = 1'b1;
              else          strobe.fuseWr = 1'b1;
            end
            OP_ERASE: begin
              stateNext    = ST_ERASE;
              eraseCntNext = CNT_LOAD;
            end
            OP_SIG_RD: begin
              strobe.rspLoad = 1'b1;
              strobe.rspSel  = RSP_SIG;
              rspNext        = 1'b1;
            end
            OP_FUSE_RD: begin
              strobe.rspLoad = 1'b1;
              strobe.rspSel  = RSP_FUSE;
              rspNext        = 1'b1;
            end
            OP_LOCK_RD: begin
              strobe.rspLoad = 1'b1;
              strobe.rspSel  = RSP_LOCK;
              rspNext        = 1'b1;
            end
            OP_FLASH_PROG: begin
              if (wrLocked) errNext = 1'b1;
              else begin
                strobe.addrLoad = 1'b1;
                wrNext          = 1'b1;
              end
            end
            OP_FLASH_VFY: begin
              if (vfyLocked) begin
                errNext        = 1'b1;
                strobe.rspLoad = 1'b1;
                strobe.rspSel  = RSP_ZERO;
                rspNext        = 1'b1;
              end else begin
                strobe.addrLoad = 1'b1;
                stateNext       = ST_VERIFY;
              end
            end
            default: ;
          endcase
        end
      end
      ST_ERASE: begin
        if (eraseCnt == '0) begin
          strobe.lockClr = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          eraseCntNext = eraseCnt - 1'b1;
        end
      end
      ST_VERIFY: begin
        strobe.rspLoad = 1'b1;
        strobe.rspSel  = RSP_FLASH;
        rspNext        = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      eraseCnt  <= '0;
      errPulse  <= 1'b0;
      rspValid  <= 1'b0;
      flashWrEn <= 1'b0;
    end else begin
      state     <= stateNext;
      eraseCnt  <= eraseCntNext;
      errPulse  <= errNext;
      rspValid  <= rspNext;
      flashWrEn <= wrNext;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign flashRdEn = (state == ST_VERIFY);

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter int                ADDR_W       = 11,
  parameter int                ERASE_CYCLES = 16,
  parameter logic [BYTE_W-1:0] CAL_BYTE     = 8'h9C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic [7:0]        flashRdData,
  output logic              busy,
  output logic              errPulse,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              flashWrEn,
  output logic              flashRdEn,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashWrData
);

  dpStrobe_t         strobe;
  logic              wrLocked;
  logic              vfyLocked;
  logic [LOCK_W-1:0] lockBits;
  logic [FUSE_W-1:0] fuseBits;

  cfg_lock_ctl #(.ERASE_CYCLES(ERASE_CYCLES)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .wrLocked (wrLocked),
    .vfyLocked(vfyLocked),
    .strobe   (strobe),
    .busy     (busy),
    .errPulse (errPulse),
    .rspValid (rspValid),
    .flashWrEn(flashWrEn),
    .flashRdEn(flashRdEn)
  );

  cfg_lock_dp #(.ADDR_W(ADDR_W), .CAL_BYTE(CAL_BYTE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .flashRdData(flashRdData),
    .lockBits   (lockBits),
    .fuseBits   (fuseBits),
    .wrLocked   (wrLocked),
    .vfyLocked  (vfyLocked),
    .rspData    (rspData),
    .flashAddr  (flashAddr),
    .flashWrData(flashWrData)
  );

endmodule

// File: rtl/cfg_lock_chk.sv
module cfg_lock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       errPulse,
  input logic       flashWrEn,
  input logic       flashRdEn,
  input logic [1:0] lockBits,
  input logic [4:0] fuseBits
);

  AST_WR_NEEDS_LB1: assert property (@(posedge clk) disable iff (!rstN)
    flashWrEn |-> lockBits[0]) else $error("write strobe while LB1 cleared"); // R3

  AST_RD_NOT_FULL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    flashRdEn |-> (lockBits != 2'b00)) else $error("verify read under full lock"); // R5

  AST_FUSE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lockBits[0]) |-> $stable(fuseBits)) else $error("fuse changed while locked"); // R3

  AST_LOCK_RISE_ON_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lockBits[0]) || $rose(lockBits[1])) |-> ($past(busy) && !busy))
    else $error("lock bit raised outside erase end"); // R6

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errPulse, flashWrEn, flashRdEn})) else $error("strobes overlap"); // R4

  AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    flashRdEn |-> busy) else $error("verify read without busy"); // R5

endmodule

bind cfg_lock_ctrl cfg_lock_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .errPulse (errPulse),
  .flashWrEn(flashWrEn),
  .flashRdEn(flashRdEn),
  .lockBits (lockBits),
  .fuseBits (fuseBits)
);

// File: tb/cfg_lock_ctrl_tb.sv
module cfg_lock_ctrl_tb;

  localparam int          ADDR_W   = 11;
  localparam int          ERASE_N  = 16;
  localparam logic [7:0]  CAL      = 8'h9C;
  localparam logic [2:0]  C_LOCKP  = 3'd0;
  localparam logic [2:0]  C_FUSEP  = 3'd1;
  localparam logic [2:0]  C_ERASE  = 3'd2;
  localparam logic [2:0]  C_SIG    = 3'd3;
  localparam logic [2:0]  C_FUSER  = 3'd4;
  localparam logic [2:0]  C_LOCKR  = 3'd5;
  localparam logic [2:0]  C_FPROG  = 3'd6;
  localparam logic [2:0]  C_VFY    = 3'd7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [2:0]        cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0]        cmdData = '0;
  logic [7:0]        flashRdData;
  logic              busy, errPulse, rspValid, flashWrEn, flashRdEn;
  logic [7:0]        rspData, flashWrData;
  logic [ADDR_W-1:0] flashAddr;

  int total = 0;
  int bad   = 0;

  logic [1:0] mLock;
  logic [4:0] mFuse;

  logic              sErr, sRsp, sWr, sRd, sBusy, sRsp2;
  logic [7:0]        sRspData, sWrData, sRspData2;
  logic [ADDR_W-1:0] sAddr;

  always #10 clk = ~clk;

  // array model: data depends on address only
  assign flashRdData = flashAddr[7:0] ^ 8'h5A;

  cfg_lock_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_N), .CAL_BYTE(CAL)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .flashRdData(flashRdData), .busy(busy), .errPulse(errPulse),
    .rspValid(rspValid), .rspData(rspData), .flashWrEn(flashWrEn), .flashRdEn(flashRdEn),
    .flashAddr(flashAddr), .flashWrData(flashWrData)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sigRef(input logic [1:0] idx, input logic hi);
    if (hi) return (idx == 2'd0) ? CAL : 8'h00;
    case (idx)
      2'd0: return 8'h1E;
      2'd1: return 8'h91;
      2'd2: return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    sErr = errPulse; sRsp = rspValid; sRspData = rspData; sWr = flashWrEn;
    sRd = flashRdEn; sBusy = busy; sAddr = flashAddr; sWrData = flashWrData;
    sRsp2 = 1'b0; sRspData2 = '0;
    if (sRd) begin
      @(negedge clk);
      sRsp2 = rspValid; sRspData2 = rspData;
    end
  endtask

  task automatic checkOp(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    logic wrLk, vfLk, eErr, eRsp, eWr, eRd;
    logic [7:0] eData;
    string req;
    wrLk = ~mLock[0];
    vfLk = (mLock == 2'b00);
    eErr = 0; eRsp = 0; eWr = 0; eRd = 0; eData = '0;
    case (op)
      C_LOCKP: req = "R9";
      C_FUSEP: begin req = wrLk ? "R3" : "R2"; eErr = wrLk; end
      C_SIG:   begin req = "R8"; eRsp = 1; eData = sigRef(a[1:0], d[0]); end
      C_FUSER: begin req = "R10"; eRsp = 1; eData = {3'b000, mFuse}; end
      C_LOCKR: begin req = "R10"; eRsp = 1; eData = {6'b0, mLock}; end
      C_FPROG: begin req = wrLk ? "R3" : "R4"; eErr = wrLk; eWr = !wrLk; end
      default: begin
        req = "R5";
        if (vfLk) begin eErr = 1; eRsp = 1; eData = 8'h00; end
        else eRd = 1;
      end
    endcase
    issue(op, a, d);
    chk(sErr == eErr, req, sErr, eErr);
    chk(sRsp == eRsp, req, sRsp, eRsp);
    if (eRsp) chk(sRspData == eData, req, sRspData, eData);
    chk(sWr == eWr, req, sWr, eWr);
    if (eWr) begin
      chk(sAddr == a, "R4", sAddr, a);
      chk(sWrData == d, "R4", sWrData, d);
    end
    chk(sRd == eRd, req, sRd, eRd);
    if (eRd) begin
      chk(sBusy == 1'b1, "R5", sBusy, 1);
      chk(sAddr == a, "R5", sAddr, a);
      chk(sRsp2 == 1'b1, "R5", sRsp2, 1);
      chk(sRspData2 == (a[7:0] ^ 8'h5A), "R5", sRspData2, a[7:0] ^ 8'h5A);
    end
    if (op == C_LOCKP) mLock = mLock & d[1:0];
    if (op == C_FUSEP && !wrLk) mFuse = mFuse & d[4:0];
  endtask

  task automatic doErase(input logic inject);
    int n;
    logic stray;
    n = 0; stray = 0;
    issue(C_ERASE, '0, 8'h00);
    while (sBusy && n < 1000) begin
      n++;
      if (errPulse || rspValid || flashWrEn || flashRdEn) stray = 1;
      if (inject) begin
        cmdValid = 1'b1;
        cmdOp    = n[0] ? C_FPROG : C_FUSEP;
        cmdAddr  = ADDR_W'(n);
        cmdData  = 8'h00;
      end
      @(negedge clk);
      sBusy = busy;
    end
    cmdValid = 1'b0;
    if (errPulse || rspValid || flashWrEn || flashRdEn) stray = 1;
    chk(n == ERASE_N, "R6", n, ERASE_N);
    chk(!stray, "R7", stray, 0);
    mLock = 2'b11;
    checkOp(C_LOCKR, '0, 8'h00);
    chk(sRspData == 8'h03, "R6", sRspData, 8'h03);
    checkOp(C_FUSER, '0, 8'h00);
    chk(sRspData == {3'b000, mFuse}, "R7", sRspData, {3'b000, mFuse});
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd2718);
    mLock = 2'b11;
    mFuse = 5'b1_0010;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && errPulse == 0 && rspValid == 0 && flashWrEn == 0 && flashRdEn == 0,
        "R1", {busy, errPulse, rspValid, flashWrEn, flashRdEn}, 0);
    checkOp(C_LOCKR, '0, 8'h00);
    chk(sRspData == 8'h03, "R1", sRspData, 8'h03);
    checkOp(C_FUSER, '0, 8'h00);
    chk(sRspData == 8'h12, "R1", sRspData, 8'h12);

    // R8 signature space
    for (int i = 0; i < 4; i++) checkOp(C_SIG, ADDR_W'(i), 8'h00);
    checkOp(C_SIG, '0, 8'h01);
    checkOp(C_SIG, 11'd1, 8'h01);

    // R2 clear-only fuse writes
    checkOp(C_FUSEP, '0, 8'h1D);
    checkOp(C_FUSEP, '0, 8'h1F);
    checkOp(C_FUSER, '0, 8'h00);
    chk(sRspData == 8'h10, "R2", sRspData, 8'h10);

    // R4 / R5 unlocked flash access
    checkOp(C_FPROG, 11'h3A5, 8'hC3);
    checkOp(C_VFY, 11'h012, 8'h00);

    // R3 write lock
    checkOp(C_LOCKP, '0, 8'hFE);
    checkOp(C_FPROG, 11'h101, 8'h55);
    @(negedge clk);
    chk(errPulse == 1'b0, "R3", errPulse, 0);
    checkOp(C_FUSEP, '0, 8'h00);
    checkOp(C_FUSER, '0, 8'h00);
    chk(sRspData == 8'h10, "R3", sRspData, 8'h10);
    checkOp(C_VFY, 11'h0F0, 8'h00);

    // R2 / R9 lock only clears; full lock
    checkOp(C_LOCKP, '0, 8'hFF);
    checkOp(C_LOCKP, '0, 8'hFD);
    checkOp(C_VFY, 11'h077, 8'h00);
    checkOp(C_LOCKR, '0, 8'h00);
    chk(sRspData == 8'h00, "R9", sRspData, 8'h00);

    // R6 / R7 erase with commands injected while busy
    doErase(1'b1);

    // LB2 alone cleared: writes still allowed
    checkOp(C_LOCKP, '0, 8'hFD);
    checkOp(C_FPROG, 11'h2AA, 8'h3C);
    checkOp(C_VFY, 11'h2AA, 8'h00);
    doErase(1'b0);

    // constrained random phase
    for (int it = 0; it < 400; it++) begin
      int unsigned r;
      logic [2:0] op;
      logic [7:0] d;
      r = $urandom % 100;
      if (r < 3) doErase(r == 0);
      else begin
        op = 3'($urandom % 8);
        if (op == C_ERASE) op = C_SIG;
        d = 8'($urandom);
        if (op == C_LOCKP && ($urandom % 4) != 0) d = 8'hFF;
        checkOp(op, ADDR_W'($urandom), d);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule